// File: doc/BRIEF.md
# Two-Wire Bus Master with Automatic Stop

This block is a single-master controller for a two-wire serial bus. Software sets up a 7-bit device address, a direction, an optional one-byte internal address and a read length. It then pulses a start command. The controller produces the START condition, the address byte with its direction bit, each data byte with its acknowledge clock, and finally the STOP condition. SCL and SDA are driven open-drain: the block only pulls a line low or lets it float, and it reads both lines back through a synchronizer. A programmable divider sets how many system clocks each SCL half-period lasts.

Writes are fed through a one-byte holding register. A transmit-ready flag tells software when the holding register may be loaded again. When a byte has been acknowledged and no new byte is waiting, the controller ends the transfer on its own with a STOP. Reads run for the programmed number of bytes. The controller acknowledges every received byte except the last, and follows the last byte with a STOP. A slave that does not acknowledge a byte sent by the master aborts the transfer and sets a sticky status flag.

The controller is a seven-state machine. The states are IDLE, START, BIT_LO, BIT_HI, STOP_LO, STOP_HI and STOP_REL. Transitions:
- IDLE→START when a start command is accepted.
- START→BIT_LO, BIT_LO→BIT_HI, STOP_LO→STOP_HI and STOP_HI→STOP_REL, each after one half-period.
- BIT_HI→BIT_LO after a data bit, or after an acknowledge slot when the transfer continues.
- BIT_HI→STOP_LO after an acknowledge slot that ends the transfer. This happens on a NACK, on a write with an empty holding register, or on the last read byte.
- STOP_REL→IDLE, which sets transfer-complete.

A byte-kind register tracks which byte is on the bus: address, internal address, write data or read data.

Top module: `i2c_master_auto_stop`

## Requirements
- R1: After reset both bus lines are released, tx_ready is 1, and rx_ready, xfer_done, nack_flag and busy are 0. Both lines stay released whenever the controller is idle.
- R2: An accepted start pulls SDA low while SCL is high (START). The first byte is then the device address, MSB first, followed by the direction bit, which is 1 for a read and 0 for a write.
- R3: Each SCL low phase lasts exactly cfg_half_div system clocks. Each high phase lasts at least that long. SDA changes only while SCL is low, except that it falls during START and rises during STOP.
- R4: On the 9th clock of each byte the master sends (address, internal address or write data), SDA is released and sampled. A high sample sets nack_flag. The flag stays set until the next accepted start clears it.
- R5: A NACK aborts the transfer at once with a STOP and sets xfer_done. Any byte waiting in the holding register is discarded, so tx_ready returns to 1.
- R6: Writing thr_data while tx_ready is 1 loads the holding register and drops tx_ready to 0. The byte moves into the shifter at the end of the preceding acknowledge, and tx_ready then returns to 1 while the transfer continues.
- R7: On a write, if a byte is acknowledged while the holding register is empty, the controller generates STOP by itself. It sets xfer_done only after the STOP condition is on the bus. A write started with an empty holding register sends only the address.
- R8: With cfg_ia_en set on a write, the cfg_ia byte is sent and acknowledged between the device address and the first data byte. The setting has no effect on reads.
- R9: A read clocks in cfg_rd_len bytes. The master drives ACK (SDA low) after each byte except the last, leaves SDA high (NACK) after the last, and then sends STOP.
- R10: Each received byte appears on rx_data, with the first bit received as the MSB. rx_ready is set when the byte lands and cleared by an rdr_rd pulse.
- R11: An accepted start clears xfer_done. A start command given while busy is ignored: the address on the bus and the number of START conditions stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle start command |
| cfg_read | input | 1 | Direction of the next transfer: 1 read, 0 write |
| cfg_dev | input | 7 | Device address |
| cfg_ia_en | input | 1 | Insert the internal-address byte on writes |
| cfg_ia | input | 8 | Internal-address byte |
| cfg_rd_len | input | CNT_W | Number of bytes to read |
| cfg_half_div | input | DIV_W | System clocks per SCL half-period (minimum 2) |
| thr_wr | input | 1 | Load thr_data into the holding register |
| thr_data | input | 8 | Byte to transmit |
| rdr_rd | input | 1 | Software has read rx_data; clears rx_ready |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| tx_ready | output | 1 | Holding register is empty |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A received byte is waiting |
| xfer_done | output | 1 | Transfer complete |
| nack_flag | output | 1 | Sticky not-acknowledged status |
| busy | output | 1 | Transfer in progress |

## Verification
A bus slave model in the bench acknowledges or refuses chosen bytes and supplies read data. It records every byte, START, STOP, master acknowledge and SCL phase length.

Writes are run in four variants:
- Two data bytes, with the second loaded only after tx_ready returns. This separates the holding-register handoff from the automatic stop.
- With and without the internal-address byte. This shows the byte order.
- With no data loaded at all. This isolates the auto-stop after the address.
- With a refused data byte and a refused address. This separates abort-and-discard from normal completion, and shows the sticky flag being cleared by the next start.

Reads of three bytes and of one byte show the ACK-except-last rule at both lengths. The read data contains bit patterns with a set MSB, a set LSB and alternating bits, so the bit order of the received byte is checked.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int BIT_CNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_REL
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_IADDR,
        PH_WDATA,
        PH_RDATA
    } byte_kind_e;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic [DEPTH-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;              // released bus reads high
            else        chain <= {chain[DEPTH-2:0], d[i]};
        end
        assign q[i] = chain[DEPTH-1];
    end

endmodule

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    assign lim  = (half_div < MIN_DIV) ? MIN_DIV : half_div;
    assign tick = en && !clr && (cnt_q >= lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clr || tick) cnt_q <= '0;
        else if (en)          cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2cm_hold.sv
module i2cm_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    input  logic         flush,
    output logic         full,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            q    <= '0;
        end else if (flush || take) begin
            full <= 1'b0;
        end else if (wr && !full) begin
            q    <= wdata;
            full <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_master_auto_stop.sv
module i2c_master_auto_stop
    import i2cm_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic                cfg_read,
    input  logic [ADDR_W-1:0]   cfg_dev,
    input  logic                cfg_ia_en,
    input  logic [BYTE_W-1:0]   cfg_ia,
    input  logic [CNT_W-1:0]    cfg_rd_len,
    input  logic [DIV_W-1:0]    cfg_half_div,
    input  logic                thr_wr,
    input  logic [BYTE_W-1:0]   thr_data,
    input  logic                rdr_rd,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                tx_ready,
    output logic [BYTE_W-1:0]   rx_data,
    output logic                rx_ready,
    output logic                xfer_done,
    output logic                nack_flag,
    output logic                busy
);
    localparam logic [BIT_CNT_W-1:0] ACK_SLOT = BIT_CNT_W'(BYTE_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]     ONE_LEFT = CNT_W'(1);

    bus_state_e             state_q, state_d;
    byte_kind_e             kind_q, kind_nx;
    logic [BYTE_W-1:0]      shift_q;
    logic [BIT_CNT_W-1:0]   bit_q;
    logic [CNT_W-1:0]       left_q;
    logic                   rd_q, ia_en_q;
    logic [BYTE_W-1:0]      ia_q;

    logic scl_s, sda_s, tick;
    logic hr_full;
    logic [BYTE_W-1:0] hr_q;

    logic start_ok, hi_end, ack_end, sends, got_nack, more_rd;
    logic go_stop, take_hr, load_ia;
    logic sda_want;

    // ---------------- line synchronizer and half-period timer -------------
    i2cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     ({scl_s, sda_s})
    );

    // the high phase only counts once SCL is seen high on the line
    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_IDLE),
        .en       (scl_oe || scl_s),
        .half_div (cfg_half_div),
        .tick     (tick)
    );

    i2cm_hold #(.W(BYTE_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (thr_wr),
        .wdata (thr_data),
        .take  (take_hr && ack_end && !got_nack),
        .flush (got_nack),
        .full  (hr_full),
        .q     (hr_q)
    );

    assign tx_ready = !hr_full;
    assign busy     = (state_q != ST_IDLE);

    // ---------------- event decode ----------------------------------------
    assign start_ok = cmd_start && (state_q == ST_IDLE);
    assign hi_end   = tick && (state_q == ST_BIT_HI);
    assign ack_end  = hi_end && (bit_q == ACK_SLOT);
    assign sends    = (kind_q != PH_RDATA);
    assign got_nack = ack_end && sends && sda_s;
    assign more_rd  = (left_q > ONE_LEFT);

    // what follows an acknowledged byte
    always_comb begin
        go_stop = 1'b0;
        take_hr = 1'b0;
        load_ia = 1'b0;
        kind_nx = kind_q;
        unique case (kind_q)
            PH_ADDR: begin
                if (rd_q) begin
                    if (left_q == '0) go_stop = 1'b1;
                    else              kind_nx = PH_RDATA;
                end else if (ia_en_q) begin
                    load_ia = 1'b1;
                    kind_nx = PH_IADDR;
                end else if (hr_full) begin
                    take_hr = 1'b1;
                    kind_nx = PH_WDATA;
                end else begin
                    go_stop = 1'b1;
                end
            end
            PH_IADDR, PH_WDATA: begin
                if (hr_full) begin
                    take_hr = 1'b1;
                    kind_nx = PH_WDATA;
                end else begin
                    go_stop = 1'b1;
                end
            end
            PH_RDATA: go_stop = !more_rd;
            default:  go_stop = 1'b1;
        endcase
    end

    // ---------------- state register --------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_ok) state_d = ST_START;
            ST_START:    if (tick)     state_d = ST_BIT_LO;
            ST_BIT_LO:   if (tick)     state_d = ST_BIT_HI;
            ST_BIT_HI: begin
                if (tick) begin
                    if (bit_q == ACK_SLOT && (got_nack || go_stop))
                        state_d = ST_STOP_LO;
                    else
                        state_d = ST_BIT_LO;
                end
            end
            ST_STOP_LO:  if (tick)     state_d = ST_STOP_HI;
            ST_STOP_HI:  if (tick)     state_d = ST_STOP_REL;
            ST_STOP_REL: if (tick)     state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // ---------------- byte datapath ---------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_q   <= '0;
            kind_q  <= PH_ADDR;
            left_q  <= '0;
            rd_q    <= 1'b0;
            ia_en_q <= 1'b0;
            ia_q    <= '0;
        end else if (start_ok) begin
            shift_q <= {cfg_dev, cfg_read};
            bit_q   <= '0;
            kind_q  <= PH_ADDR;
            left_q  <= cfg_rd_len;
            rd_q    <= cfg_read;
            ia_en_q <= cfg_ia_en && !cfg_read;
            ia_q    <= cfg_ia;
        end else if (hi_end) begin
            if (bit_q != ACK_SLOT) begin
                shift_q <= {shift_q[BYTE_W-2:0], sends ? 1'b0 : sda_s};
                bit_q   <= bit_q + 1'b1;
            end else begin
                bit_q <= '0;
                if (!got_nack) begin
                    kind_q <= kind_nx;
                    if (load_ia) shift_q <= ia_q;
                    if (take_hr) shift_q <= hr_q;
                    if (kind_q == PH_RDATA) left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // ---------------- receive register and status -------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
        end else if (hi_end && bit_q == LAST_BIT && !sends) begin
            rx_data  <= {shift_q[BYTE_W-2:0], sda_s};
            rx_ready <= 1'b1;
        end else if (rdr_rd) begin
            rx_ready <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_done <= 1'b0;
            nack_flag <= 1'b0;
        end else if (start_ok) begin
            xfer_done <= 1'b0;
            nack_flag <= 1'b0;
        end else begin
            if (got_nack) nack_flag <= 1'b1;
            if (tick && state_q == ST_STOP_REL) xfer_done <= 1'b1;
        end
    end

    // ---------------- bus outputs -----------------------------------------
    always_comb begin
        scl_oe   = 1'b0;
        sda_want = 1'b0;
        unique case (state_q)
            ST_IDLE:     sda_want = 1'b0;
            ST_START:    sda_want = 1'b1;
            ST_BIT_LO, ST_BIT_HI: begin
                scl_oe = (state_q == ST_BIT_LO);
                if (bit_q != ACK_SLOT) sda_want = sends && !shift_q[BYTE_W-1];
                else                   sda_want = !sends && more_rd;
            end
            ST_STOP_LO: begin
                scl_oe   = 1'b1;
                sda_want = 1'b1;
            end
            ST_STOP_HI:  sda_want = 1'b1;
            ST_STOP_REL: sda_want = 1'b0;
            default:     sda_want = 1'b0;
        endcase
    end

    // SDA trails SCL by one clock so data moves only inside the low phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_oe <= 1'b0;
        else        sda_oe <= sda_want;
    end

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       cmd_start,
    input logic       busy,
    input logic       tx_ready,
    input logic       xfer_done,
    input logic       nack_flag,
    input bus_state_e st
);
    // R3: SDA is pulled low with SCL high only as the START condition
    p_start_only_in_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> (st == ST_START));

    // R3: SDA is released with SCL high only as the STOP condition
    p_stop_only_in_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> (st == ST_STOP_REL));

    // R4: the not-acknowledged flag holds until a start is accepted
    p_nack_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_flag && !(cmd_start && !busy)) |=> nack_flag);

    // R5: a refused byte leaves the holding register empty
    p_nack_flushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_flag) |-> tx_ready);

    // R7: completion is signalled only after the stop release phase
    p_done_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done) |-> ($past(st) == ST_STOP_REL));

    // R1: both lines float while idle
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (!scl_oe && !sda_oe));

    // R11: an accepted start clears completion
    p_start_clears_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> !xfer_done);

endmodule

bind i2c_master_auto_stop i2cm_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .cmd_start (cmd_start),
    .busy      (busy),
    .tx_ready  (tx_ready),
    .xfer_done (xfer_done),
    .nack_flag (nack_flag),
    .st        (state_q)
);

// File: tb/i2c_master_auto_stop_tb.sv
module i2c_master_auto_stop_tb;

    localparam int DIV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        cmd_start, cfg_read, cfg_ia_en, thr_wr, rdr_rd;
    logic [6:0]  cfg_dev;
    logic [7:0]  cfg_ia, cfg_rd_len, thr_data;
    logic [15:0] cfg_half_div;
    logic        scl_oe, sda_oe, tx_ready, rx_ready, xfer_done, nack_flag, busy;
    logic [7:0]  rx_data;
    logic        scl_line, sda_line, slv_low;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slv_low);

    i2c_master_auto_stop u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cfg_read(cfg_read),
        .cfg_dev(cfg_dev), .cfg_ia_en(cfg_ia_en), .cfg_ia(cfg_ia),
        .cfg_rd_len(cfg_rd_len), .cfg_half_div(cfg_half_div),
        .thr_wr(thr_wr), .thr_data(thr_data), .rdr_rd(rdr_rd),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_ready(tx_ready), .rx_data(rx_data),
        .rx_ready(rx_ready), .xfer_done(xfer_done), .nack_flag(nack_flag), .busy(busy)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- slave model (task-side controls) ----------------
    logic       clr_req;
    int         nack_at;
    logic [7:0] src [4];

    // ---------------- slave model (recorded state) --------------------
    logic       prev_scl, prev_sda, slv_tx, m_ack, seen;
    logic [7:0] shreg, cur;
    int         cnt, byte_idx, tx_idx, run;
    logic [7:0] rec [16];
    int         rec_n, starts, stops;
    logic       macks [8];
    int         mack_n, lo_min, lo_max, hi_min;

    initial begin
        slv_low = 1'b0; prev_scl = 1'b1; prev_sda = 1'b1;
    end

    always @(negedge clk) begin
        if (clr_req) begin
            slv_low = 1'b0; slv_tx = 1'b0; m_ack = 1'b0; seen = 1'b0;
            cnt = 0; byte_idx = 0; tx_idx = 0; run = 0;
            rec_n = 0; starts = 0; stops = 0; mack_n = 0;
            lo_min = 99999; lo_max = 0; hi_min = 99999;
            shreg = 8'h00; cur = 8'h00;
        end else begin
            if (busy) begin
                if (scl_line == prev_scl) run++;
                else begin
                    if (seen && prev_scl)  hi_min = (run < hi_min) ? run : hi_min;
                    if (seen && !prev_scl) begin
                        lo_min = (run < lo_min) ? run : lo_min;
                        lo_max = (run > lo_max) ? run : lo_max;
                    end
                    seen = 1'b1;
                    run = 1;
                end
            end else begin
                seen = 1'b0;
                run = 0;
            end

            if (scl_line && prev_scl && prev_sda && !sda_line) begin
                starts++; cnt = 0; byte_idx = 0; slv_tx = 1'b0; slv_low = 1'b0;
            end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
                stops++; cnt = 0; slv_tx = 1'b0;
            end else if (scl_line && !prev_scl) begin
                if (cnt < 8) shreg = {shreg[6:0], sda_line};
                else if (cnt == 8 && slv_tx) begin
                    macks[mack_n] = sda_line; mack_n++; m_ack = sda_line;
                end
                cnt++;
            end else if (!scl_line && prev_scl) begin
                if (cnt == 8) begin
                    if (!slv_tx) begin
                        rec[rec_n] = shreg; rec_n++;
                        slv_low = (byte_idx != nack_at);
                    end else slv_low = 1'b0;
                end else if (cnt == 9) begin
                    cnt = 0;
                    if (!slv_tx && byte_idx == 0 && shreg[0]) begin
                        slv_tx = 1'b1; m_ack = 1'b0; tx_idx = 0;
                    end
                    byte_idx++;
                    if (slv_tx && !m_ack) begin
                        cur = src[tx_idx]; tx_idx++; slv_low = !cur[7];
                    end else slv_low = 1'b0;
                end else if (cnt >= 1 && cnt <= 7 && slv_tx) begin
                    slv_low = !cur[7-cnt];
                end
            end
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    // ---------------- watchdog ----------------------------------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
            $finish;
        end
    end

    // ---------------- helpers -----------------------------------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_slave(input int nk);
        nack_at = nk;
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
    endtask

    task automatic load_thr(input logic [7:0] b);
        thr_data = b; thr_wr = 1'b1;
        @(negedge clk);
        thr_wr = 1'b0;
    endtask

    task automatic go(input logic rd, input logic [6:0] dev, input logic iae,
                      input logic [7:0] ia, input logic [7:0] len);
        cfg_read = rd; cfg_dev = dev; cfg_ia_en = iae; cfg_ia = ia; cfg_rd_len = len;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!xfer_done && n < 20000) begin @(negedge clk); n++; end
        chk(req, "transfer completes", int'(xfer_done), 1);
    endtask

    task automatic wait_txr(input string req);
        int n = 0;
        while (!tx_ready && n < 5000) begin @(negedge clk); n++; end
        chk(req, "tx_ready returns mid-transfer", int'(tx_ready && busy), 1);
    endtask

    // ---------------- scenarios ---------------------------------------
    task automatic t_reset();
        chk("R1", "scl released", int'(scl_oe), 0);
        chk("R1", "sda released", int'(sda_oe), 0);
        chk("R1", "tx_ready", int'(tx_ready), 1);
        chk("R1", "rx_ready", int'(rx_ready), 0);
        chk("R1", "xfer_done", int'(xfer_done), 0);
        chk("R1", "nack_flag", int'(nack_flag), 0);
        chk("R1", "busy", int'(busy), 0);
    endtask

    task automatic t_write_two();
        clear_slave(-1);
        load_thr(8'h11);
        chk("R6", "tx_ready low after load", int'(tx_ready), 0);
        go(1'b0, 7'h50, 1'b0, 8'h00, 8'd0);
        chk("R11", "busy after start", int'(busy), 1);
        wait_txr("R6");
        load_thr(8'h22);
        chk("R6", "tx_ready low after second load", int'(tx_ready), 0);
        wait_done("R7");
        chk("R2", "byte count", rec_n, 3);
        chk("R2", "address byte, write bit 0", int'(rec[0]), 'hA0);
        chk("R6", "first data byte", int'(rec[1]), 'h11);
        chk("R6", "second data byte", int'(rec[2]), 'h22);
        chk("R7", "one STOP on bus before done", stops, 1);
        chk("R4", "no nack", int'(nack_flag), 0);
        chk("R3", "min SCL low", lo_min, DIV);
        chk("R3", "max SCL low", lo_max, DIV);
        chk("R3", "SCL high long enough", int'(hi_min >= DIV), 1);
    endtask

    task automatic t_write_iaddr();
        clear_slave(-1);
        load_thr(8'h5A);
        chk("R11", "done still set before start", int'(xfer_done), 1);
        go(1'b0, 7'h2B, 1'b1, 8'h3C, 8'd0);
        chk("R11", "done cleared on start", int'(xfer_done), 0);
        repeat (40) @(negedge clk);
        go(1'b1, 7'h7F, 1'b0, 8'h00, 8'd2);   // ignored while busy
        wait_done("R8");
        chk("R8", "byte count", rec_n, 3);
        chk("R11", "address unchanged by ignored start", int'(rec[0]), 'h56);
        chk("R8", "internal address second", int'(rec[1]), 'h3C);
        chk("R8", "data third", int'(rec[2]), 'h5A);
        chk("R11", "single START", starts, 1);
    endtask

    task automatic t_write_empty();
        clear_slave(-1);
        go(1'b0, 7'h11, 1'b0, 8'h00, 8'd0);
        wait_done("R7");
        chk("R7", "only address sent", rec_n, 1);
        chk("R7", "address value", int'(rec[0]), 'h22);
        chk("R7", "auto STOP", stops, 1);
    endtask

    task automatic t_nack_data();
        clear_slave(1);
        load_thr(8'h77);
        go(1'b0, 7'h44, 1'b0, 8'h00, 8'd0);
        wait_txr("R6");
        load_thr(8'h88);
        wait_done("R5");
        chk("R4", "nack set", int'(nack_flag), 1);
        chk("R5", "aborted after refused byte", rec_n, 2);
        chk("R5", "pending byte discarded", int'(tx_ready), 1);
        chk("R5", "STOP sent", stops, 1);
        repeat (50) @(negedge clk);
        chk("R4", "nack sticky", int'(nack_flag), 1);
    endtask

    task automatic t_nack_addr();
        clear_slave(0);
        load_thr(8'h99);
        go(1'b0, 7'h33, 1'b0, 8'h00, 8'd0);
        chk("R4", "nack cleared by start", int'(nack_flag), 0);
        wait_done("R5");
        chk("R4", "nack on address", int'(nack_flag), 1);
        chk("R5", "only address on bus", rec_n, 1);
        chk("R5", "holding byte discarded", int'(tx_ready), 1);
        chk("R5", "STOP sent", stops, 1);
    endtask

    task automatic t_read(input int len);
        clear_slave(-1);
        src[0] = 8'hC3; src[1] = 8'h5A; src[2] = 8'h81; src[3] = 8'h00;
        if (len == 1) src[0] = 8'h5E;
        go(1'b1, 7'h21, 1'b1, 8'hEE, 8'(len));
        for (int i = 0; i < len; i++) begin
            int n = 0;
            while (!rx_ready && n < 5000) begin @(negedge clk); n++; end
            chk("R10", "rx_ready set", int'(rx_ready), 1);
            chk("R10", "received byte", int'(rx_data), int'(src[i]));
            rdr_rd = 1'b1;
            @(negedge clk);
            rdr_rd = 1'b0;
            chk("R10", "rx_ready cleared by read", int'(rx_ready), 0);
        end
        wait_done("R9");
        chk("R2", "address byte, read bit 1", int'(rec[0]), 'h43);
        chk("R8", "no internal address on read", rec_n, 1);
        chk("R9", "master ack count", mack_n, len);
        for (int i = 0; i < len; i++)
            chk("R9", "ACK low except last", int'(macks[i]), (i == len - 1) ? 1 : 0);
        chk("R9", "STOP after last", stops, 1);
        chk("R4", "no nack on read", int'(nack_flag), 0);
    endtask

    initial begin
        cmd_start = 0; cfg_read = 0; cfg_ia_en = 0; thr_wr = 0; rdr_rd = 0;
        cfg_dev = '0; cfg_ia = '0; cfg_rd_len = '0; thr_data = '0;
        cfg_half_div = 16'(DIV); nack_at = -1; clr_req = 1'b1;
        src[0] = 0; src[1] = 0; src[2] = 0; src[3] = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        clr_req = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_two();
        t_write_iaddr();
        t_write_empty();
        t_nack_data();
        t_nack_addr();
        t_read(3);
        t_read(1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule